// File: doc/BRIEF.md
# Prioritised Exception Entry Controller

This block sits next to a small processor core and performs exception entry in hardware. Each cycle it looks at seven exception request lines. It drops any interrupt request that the current status word masks, and picks the highest-priority request that remains. In the cycle after it samples a request, it reports the whole entry through write strobes. These strobes load the program counter with the vector address, write the return address into the link register of the target mode, and load a new status word. The new status word carries the target mode code and the interrupt masks that go with that exception. At the same clock edge the block saves the old status word in an internal saved-status bank that has one entry for each privileged mode.

The block also carries out exception return. When the core raises the return request, the block reads the saved status of the mode the core is currently in and sends it back through the status write strobe. This restores mode, masks and condition flags in one step. The core owns the current status and the program counter. It applies each strobe at the next clock edge and feeds the updated values back in. The block ignores its inputs in the cycle that follows any strobe, so it never acts on a stale status.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The request bits are indexed 0 reset, 1 data abort, 2 FIQ, 3 IRQ, 4 prefetch abort, 5 software interrupt, 6 undefined instruction. The lowest-indexed eligible request is taken.
- R2: A FIQ request is ignored while status bit 6 (F) is set, and an IRQ request is ignored while status bit 7 (I) is set. The masks never block any other request. If no request is eligible, no strobe is produced.
- R3: On entry `lr_o` equals the sampled `pc_i` minus 4, and `lr_mode_o` names the target mode.
- R4: On entry `pc_o` equals `VEC_BASE` plus the vector offset of the taken exception: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C.
- R5: The entry status equals the sampled status with bits 4:0 replaced by the target mode code and bit 7 set. Bit 6 is also set for FIQ and reset. All other bits are unchanged. The mode codes are: reset and software interrupt 0x13, both aborts 0x17, IRQ 0x12, FIQ 0x11, undefined 0x1B.
- R6: One cycle after a request is sampled, `ack_o` carries the one-hot bit of the taken exception, and `pc_we_o`, `lr_we_o` and `st_we_o` pulse together with it.
- R7: On entry the sampled status is written into the saved-status entry of the target mode.
- R8: A return request drives `st_we_o` with the saved status of the mode in status bits 4:0. The request is ignored when that mode has no saved-status entry (user 0x10, system 0x1F).
- R9: When an eligible exception and a return request arrive in the same cycle, the exception is taken and the return is dropped.
- R10: In the cycle after any status strobe, requests and return requests are ignored.
- R11: While synchronous reset is high, all strobes and `ack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Exception requests, indexed by priority |
| ret_i | input | 1 | Exception-return request |
| pc_i | input | AW | Current program counter |
| status_i | input | DW | Current status word |
| ack_o | output | 7 | One-hot code of the exception taken |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_o | output | AW | Vector address |
| lr_we_o | output | 1 | Link register write strobe |
| lr_mode_o | output | 5 | Mode whose link register is written |
| lr_o | output | AW | Return address |
| st_we_o | output | 1 | Status write strobe |
| st_o | output | DW | New status word |

## Verification
The bench sweeps every request pattern under all four combinations of the F and I masks. For each pattern it checks the taken exception, the vector, the link value and the new status, and then issues a return to check that the saved status comes back.

The sweep targets specific errors:
- A swapped priority between the data abort and FIQ requests would show up as a wrong acknowledge.
- A mask that also blocked a non-interrupt request would show up as a wrong acknowledge.
- A FIQ entry that left I clear would show up as a wrong status word.
- A saved status stored in the wrong bank entry would show up as a wrong restored value.

Directed cases cover three further points. A request held for several cycles must skip the cycle after an acknowledge. A return that collides with a request must lose. A return from user or system mode must produce no strobe.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int NEXC    = 7;
  localparam int IDX_W   = 3;
  localparam int NBANK   = 5;
  localparam int BANK_AW = 3;
  localparam int MODE_W  = 5;
  localparam int FBIT    = 6;
  localparam int IBIT    = 7;

  localparam int X_RST  = 0;
  localparam int X_DABT = 1;
  localparam int X_FIQ  = 2;
  localparam int X_IRQ  = 3;
  localparam int X_PABT = 4;
  localparam int X_SWI  = 5;
  localparam int X_UND  = 6;

  typedef logic [MODE_W-1:0] mode_t;

  localparam mode_t M_USR = 5'h10;
  localparam mode_t M_FIQ = 5'h11;
  localparam mode_t M_IRQ = 5'h12;
  localparam mode_t M_SVC = 5'h13;
  localparam mode_t M_ABT = 5'h17;
  localparam mode_t M_UND = 5'h1B;
  localparam mode_t M_SYS = 5'h1F;

  function automatic mode_t exc_mode(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      X_RST, X_SWI:   return M_SVC;
      X_DABT, X_PABT: return M_ABT;
      X_FIQ:          return M_FIQ;
      X_IRQ:          return M_IRQ;
      default:        return M_UND;
    endcase
  endfunction

  function automatic logic [7:0] exc_vec_ofs(input logic [IDX_W-1:0] idx);
    case (int'(idx))
      X_RST:   return 8'h00;
      X_UND:   return 8'h04;
      X_SWI:   return 8'h08;
      X_PABT:  return 8'h0C;
      X_DABT:  return 8'h10;
      X_IRQ:   return 8'h18;
      default: return 8'h1C;
    endcase
  endfunction

  function automatic logic exc_sets_f(input logic [IDX_W-1:0] idx);
    return (int'(idx) == X_FIQ) || (int'(idx) == X_RST);
  endfunction

  function automatic logic mode_banked(input mode_t m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BANK_AW-1:0] mode_slot(input mode_t m);
    case (m)
      M_FIQ:   return 3'd0;
      M_IRQ:   return 3'd1;
      M_SVC:   return 3'd2;
      M_ABT:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_pkg::*;
#(
  parameter int N = NEXC
) (
  input  logic [N-1:0] req_i,
  input  logic         fmask_i,
  input  logic         imask_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  logic [N-1:0] elig;
  logic [N:0]   above;

  assign above[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_lane
      if (g == X_FIQ) begin : g_fiq
        assign elig[g] = req_i[g] & ~fmask_i;
      end else if (g == X_IRQ) begin : g_irq
        assign elig[g] = req_i[g] & ~imask_i;
      end else begin : g_plain
        assign elig[g] = req_i[g];
      end
      assign grant_o[g]  = elig[g] & ~above[g];
      assign above[g+1]  = above[g] | elig[g];
    end
  endgenerate

  assign any_o = above[N];

endmodule

// File: rtl/exc_sbank.sv
module exc_sbank #(
  parameter int DW    = 32,
  parameter int DEPTH = 5,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int             AW       = 32,
  parameter int             DW       = 32,
  parameter logic [AW-1:0]  VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NEXC-1:0]   req_i,
  input  logic              ret_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     status_i,
  output logic [NEXC-1:0]   ack_o,
  output logic              pc_we_o,
  output logic [AW-1:0]     pc_o,
  output logic              lr_we_o,
  output logic [MODE_W-1:0] lr_mode_o,
  output logic [AW-1:0]     lr_o,
  output logic              st_we_o,
  output logic [DW-1:0]     st_o
);

  localparam logic [AW-1:0] LINK_OFS = AW'(4);

  logic              busy;
  logic [NEXC-1:0]   req_gated;
  logic [NEXC-1:0]   grant;
  logic              any_req;
  logic [IDX_W-1:0]  sel;
  mode_t             tgt_mode;
  mode_t             cur_mode;
  logic              take;
  logic              do_ret;
  logic [DW-1:0]     ent_st;
  logic [DW-1:0]     saved_st;

  assign busy      = st_we_o;
  assign req_gated = busy ? '0 : req_i;
  assign cur_mode  = status_i[MODE_W-1:0];

  exc_prio_arb #(.N(NEXC)) u_arb (
    .req_i   (req_gated),
    .fmask_i (status_i[FBIT]),
    .imask_i (status_i[IBIT]),
    .grant_o (grant),
    .any_o   (any_req)
  );

  always_comb begin
    sel = '0;
    for (int k = 0; k < NEXC; k++) begin
      if (grant[k]) sel = IDX_W'(k);
    end
  end

  assign tgt_mode = exc_mode(sel);
  assign take     = any_req;
  assign do_ret   = ret_i & ~busy & ~any_req & mode_banked(cur_mode);

  always_comb begin
    ent_st               = status_i;
    ent_st[MODE_W-1:0]   = tgt_mode;
    ent_st[IBIT]         = 1'b1;
    if (exc_sets_f(sel)) ent_st[FBIT] = 1'b1;
  end

  exc_sbank #(.DW(DW), .DEPTH(NBANK), .AW(BANK_AW)) u_bank (
    .clk     (clk),
    .we_i    (take),
    .waddr_i (mode_slot(tgt_mode)),
    .wdata_i (status_i),
    .raddr_i (mode_slot(cur_mode)),
    .rdata_o (saved_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o     <= '0;
      pc_we_o   <= 1'b0;
      pc_o      <= '0;
      lr_we_o   <= 1'b0;
      lr_mode_o <= '0;
      lr_o      <= '0;
      st_we_o   <= 1'b0;
      st_o      <= '0;
    end else begin
      ack_o   <= grant;
      pc_we_o <= take;
      lr_we_o <= take;
      st_we_o <= take | do_ret;
      if (take) begin
        pc_o      <= VEC_BASE + AW'(exc_vec_ofs(sel));
        lr_mode_o <= tgt_mode;
        lr_o      <= pc_i - LINK_OFS;
        st_o      <= ent_st;
      end else if (do_ret) begin
        st_o      <= saved_st;
      end
    end
  end

  // R1
  arb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_o));

  // R6
  ack_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack_o) |-> (pc_we_o && lr_we_o && st_we_o));

  // R10
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    st_we_o |=> !st_we_o);

  // R5
  fiq_masks_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o[X_FIQ] |-> (st_o[FBIT] && st_o[IBIT] && st_o[MODE_W-1:0] == M_FIQ));

  // R2
  fiq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o[X_FIQ] |-> !$past(status_i[FBIT]));

  // R3
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we_o |-> (lr_o == $past(pc_i) - LINK_OFS));

  // R8
  ret_source_chk: assert property (@(posedge clk) disable iff (rst)
    (st_we_o && !pc_we_o) |-> $past(ret_i));

endmodule

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] VBASE      = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  req = '0;
  logic        ret = 1'b0;
  logic [31:0] pc  = '0;
  logic [31:0] st  = '0;
  logic [6:0]  ack_o;
  logic        pc_we_o, lr_we_o, st_we_o;
  logic [31:0] pc_o, lr_o, st_o;
  logic [4:0]  lr_mode_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl #(.AW(32), .DW(32), .VEC_BASE(VBASE)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .ret_i(ret), .pc_i(pc), .status_i(st),
    .ack_o(ack_o), .pc_we_o(pc_we_o), .pc_o(pc_o), .lr_we_o(lr_we_o),
    .lr_mode_o(lr_mode_o), .lr_o(lr_o), .st_we_o(st_we_o), .st_o(st_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [6:0] r, input logic rt, input logic [31:0] p,
                      input logic [31:0] s);
    @(negedge clk);
    req = r; ret = rt; pc = p; st = s;
    @(negedge clk);
    req = '0; ret = 1'b0;
  endtask

  function automatic logic [4:0] ref_mode(input int e);
    case (e)
      0, 5:    return 5'h13;
      1, 4:    return 5'h17;
      2:       return 5'h11;
      3:       return 5'h12;
      default: return 5'h1B;
    endcase
  endfunction

  function automatic logic [31:0] ref_vec(input int e);
    case (e)
      0: return 32'h00; 1: return 32'h10; 2: return 32'h1C; 3: return 32'h18;
      4: return 32'h0C; 5: return 32'h08; default: return 32'h04;
    endcase
  endfunction

  function automatic logic [31:0] ref_status(input int e, input logic [31:0] s);
    logic [31:0] v;
    v = {s[31:8], 1'b1, (e == 0 || e == 2) ? 1'b1 : s[6], s[5], ref_mode(e)};
    return v;
  endfunction

  function automatic int ref_pick(input logic [6:0] r, input logic f, input logic i);
    for (int k = 0; k < 7; k++) begin
      if (r[k] && !(k == 2 && f) && !(k == 3 && i)) return k;
    end
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11: strobes low while reset is held, even with requests present
    req = 7'h7F; ret = 1'b1; st = 32'h13;
    repeat (3) @(negedge clk);
    chk(ack_o == 0 && !pc_we_o && !lr_we_o && !st_we_o, "R11 reset",
        {25'd0, ack_o}, 32'd0);
    req = '0; ret = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Sweep: every request pattern under every mask pair
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 128; r++) begin
        logic [31:0] pat, s, p, es;
        int e;
        pat = (r * 32'h0135_79BD) ^ (m * 32'h9E37_0000);
        s   = {pat[31:8], m[1], m[0], pat[5], 5'h10};
        p   = {pat[31:2] ^ 30'h2AA, 2'b00};
        e   = ref_pick(7'(r), m[0], m[1]);
        fire(7'(r), 1'b0, p, s);
        if (e < 0) begin
          // R2: nothing eligible, nothing taken
          chk(ack_o == 0 && !st_we_o && !pc_we_o, "R2 masked", {25'd0, ack_o}, 32'd0);
        end else begin
          es = ref_status(e, s);
          // R1 R6
          chk(ack_o == 7'(1 << e), "R1 pick", {25'd0, ack_o}, 32'(1 << e));
          chk(pc_we_o && lr_we_o && st_we_o, "R6 strobes",
              {29'd0, pc_we_o, lr_we_o, st_we_o}, 32'd7);
          // R4
          chk(pc_o == VBASE + ref_vec(e), "R4 vector", pc_o, VBASE + ref_vec(e));
          // R3
          chk(lr_o == p - 32'd4 && lr_mode_o == ref_mode(e), "R3 link", lr_o, p - 32'd4);
          // R5
          chk(st_o == es, "R5 status", st_o, es);
          // R7 R8: return from the new mode restores the saved status
          fire(7'd0, 1'b1, 32'd0, es);
          chk(st_we_o && !pc_we_o && st_o == s, "R7 R8 restore", st_o, s);
        end
      end
    end

    // R8: return from user and system mode is ignored
    fire(7'd0, 1'b1, 32'd0, 32'h0000_0010);
    chk(!st_we_o, "R8 user ret", {31'd0, st_we_o}, 32'd0);
    fire(7'd0, 1'b1, 32'd0, 32'h0000_001F);
    chk(!st_we_o, "R8 system ret", {31'd0, st_we_o}, 32'd0);

    // R9: exception wins over a simultaneous return
    fire(7'b010_0000, 1'b1, 32'h0000_2000, 32'h5000_0012);
    chk(ack_o == 7'b010_0000 && st_o == 32'h5000_0093, "R9 collision", st_o, 32'h5000_0093);

    // R10: a held IRQ request skips the cycle after its acknowledge
    @(negedge clk);
    req = 7'b000_1000; st = 32'h0000_0010; pc = 32'h400;
    @(negedge clk);
    chk(ack_o == 7'b000_1000, "R10 first", {25'd0, ack_o}, 32'h08);
    @(negedge clk);
    chk(ack_o == 0 && !st_we_o, "R10 gap", {25'd0, ack_o}, 32'd0);
    @(negedge clk);
    chk(ack_o == 7'b000_1000, "R10 again", {25'd0, ack_o}, 32'h08);
    req = '0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule